// File: doc/BRIEF.md
# I2C FIFO Threshold Event Logic

This block sits between the host side and the serial bus engine of an I2C controller. It holds a transmit byte FIFO and a receive byte FIFO, and it tracks how many bytes of the current transfer are still to move. From the FIFO fill levels, the programmed thresholds and the remaining byte counts it raises events. These events let software move data in bursts whose size equals the threshold. Near the end of a transfer, when a full burst can no longer occur, a separate "draining" event replaces the ordinary request.

A transfer begins with a start pulse that carries the byte count and the direction. The host pushes transmit bytes and pops receive bytes. The bus engine pops transmit bytes and pushes receive bytes, and it also reports completion, a missing acknowledge and lost arbitration. Every event lands in a sticky status vector. A bit in that vector is cleared by writing one to it. An enable mask selects which status bits drive the single interrupt output. A configuration write sets both thresholds and can flush either FIFO.

Top module: `i2c_fifo_evt`

## Requirements
- R1: After reset, `status`, `irq`, `tx_level` and `rx_level` are all zero. `depth_code` equals the DEPTH_CODE parameter, and the FIFO depth is 8 shifted left by that code (8 by default).
- R2: On a `cfg_wr`, the transmit threshold minus one is taken from `cfg_wdata[5:0]` and the receive threshold minus one from `cfg_wdata[13:8]`. Each effective threshold therefore lies between 1 and 64. Both fields reset to 0, which gives a threshold of 1.
- R3: In a transmit transfer (`xfer_rx`=0 at start), status bit 0 (transmit request) is set when all of these hold: bytes still to be pushed by the host are non-zero and at least the transmit threshold, and `tx_level` is below the transmit threshold.
- R4: In a transmit transfer, status bit 1 (transmit drain) is set instead of bit 0 when the bytes still to be pushed are non-zero but fewer than the threshold, and `tx_level` is below the threshold.
- R5: In a receive transfer (`xfer_rx`=1 at start), status bit 2 (receive request) is set when `rx_level` is at least the receive threshold.
- R6: In a receive transfer, status bit 3 (receive drain) is set when all transfer bytes have been accepted from the engine and `rx_level` is non-zero but below the receive threshold.
- R7: `eng_done`, `eng_nack` and `eng_arb_lost` set status bits 4, 5 and 6 respectively, one cycle after the pulse.
- R8: Status bits are sticky. A one in `sts_clr` clears that bit one cycle later, unless its set condition holds in the same cycle, in which case setting wins. A zero in `sts_clr` has no effect.
- R9: `irq` is high exactly when some status bit and its `irq_en` bit are both one. `irq` is updated in the same cycle as `status`.
- R10: On a `cfg_wr`, `cfg_wdata[6]` empties the transmit FIFO and `cfg_wdata[14]` empties the receive FIFO. Each flush acts independently of the other.
- R11: A host push into a full transmit FIFO is dropped. It changes neither the level nor the stored bytes, and it does not count toward the transfer.
- R12: A host read while the receive FIFO is empty leaves `host_rdata` at its last value and leaves `rx_level` at zero.
- R13: Both FIFOs deliver bytes in the order they were pushed. A popped byte appears on the data output one cycle after the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Loads the transfer length and direction |
| xfer_len | input | CW | Transfer length in bytes |
| xfer_rx | input | 1 | Direction: 1 receive, 0 transmit |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Threshold fields and flush bits |
| host_wr | input | 1 | Host pushes a transmit byte |
| host_wdata | input | DW | Transmit byte from the host |
| host_rd | input | 1 | Host pops a receive byte |
| host_rdata | output | DW | Last receive byte popped |
| eng_tx_pop | input | 1 | Engine pops a transmit byte |
| eng_tx_data | output | DW | Last transmit byte popped |
| eng_rx_push | input | 1 | Engine pushes a receive byte |
| eng_rx_data | input | DW | Receive byte from the engine |
| eng_done | input | 1 | Transaction complete pulse |
| eng_nack | input | 1 | Missing acknowledge pulse |
| eng_arb_lost | input | 1 | Arbitration lost pulse |
| sts_clr | input | 7 | Write-one-to-clear mask for status |
| irq_en | input | 7 | Interrupt enable per status bit |
| status | output | 7 | Sticky event status |
| irq | output | 1 | Interrupt request |
| tx_level | output | LW | Transmit FIFO fill |
| rx_level | output | LW | Receive FIFO fill |
| depth_code | output | 4 | Encoded FIFO depth |

## Verification
Several faults show up at the ports as a status bit that cannot be cleared, or that is set in the wrong place. Examples are a remaining-byte counter that drifts by one, an off-by-one threshold decode, or a dropped push that is still counted. The status vector is cleared after every single push and then re-read, so one cycle after the cause the bit shows only the live condition. The sweeps cover every threshold from 1 up to one above the FIFO depth and every length up to 10. This exposes compare-boundary errors on the very push where they first matter. Broken FIFO ordering or a corrupted full or empty guard shows up in the popped data sequence and in the level outputs.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
  localparam int NEV       = 7;
  localparam int EV_TXREQ  = 0;
  localparam int EV_TXDRN  = 1;
  localparam int EV_RXREQ  = 2;
  localparam int EV_RXDRN  = 3;
  localparam int EV_DONE   = 4;
  localparam int EV_NACK   = 5;
  localparam int EV_ARB    = 6;
  localparam int THR_W     = 6;
  localparam int CFG_TX_LSB  = 0;
  localparam int CFG_RX_LSB  = 8;
  localparam int CFG_TXFLUSH = 6;
  localparam int CFG_RXFLUSH = 14;
endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  assign do_push = push && !flush && (level != LW'(DEPTH));
  assign do_pop  = pop  && !flush && (level != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (do_pop) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end
endmodule

// File: rtl/i2cf_left_ctr.sv
module i2cf_left_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  input  logic          dec,
  output logic [CW-1:0] left
);
  always_ff @(posedge clk) begin
    if (rst) left <= '0;
    else if (load) left <= len;
    else if (dec && left != '0) left <= left - CW'(1);
  end
endmodule

// File: rtl/i2cf_status.sv
module i2cf_status #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] sts,
  output logic         irq
);
  logic [N-1:0] sts_d;
  assign sts_d = (sts & ~clr) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      irq <= 1'b0;
    end else begin
      sts <= sts_d;
      irq <= |(sts_d & en);
    end
  end
endmodule

// File: rtl/i2c_fifo_evt.sv
module i2c_fifo_evt
  import i2cf_pkg::*;
#(
  parameter int DW         = 8,
  parameter int DEPTH_CODE = 0,
  parameter int CW         = 16,
  localparam int DEPTH     = 8 << DEPTH_CODE,
  localparam int LW        = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_start,
  input  logic [CW-1:0] xfer_len,
  input  logic          xfer_rx,
  input  logic          cfg_wr,
  input  logic [15:0]   cfg_wdata,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          eng_tx_pop,
  output logic [DW-1:0] eng_tx_data,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          eng_done,
  input  logic          eng_nack,
  input  logic          eng_arb_lost,
  input  logic [6:0]    sts_clr,
  input  logic [6:0]    irq_en,
  output logic [6:0]    status,
  output logic          irq,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic [3:0]    depth_code
);
  localparam int CMPW = CW + 1;

  logic             rx_mode;
  logic [THR_W-1:0] tx_thr_m1, rx_thr_m1;
  logic             tx_flush, rx_flush;
  logic             tx_acc, rx_acc;
  logic [CW-1:0]    host_left, eng_left;
  logic [CMPW-1:0]  tx_thr, rx_thr, tx_lv, rx_lv, h_left, e_left;
  logic [NEV-1:0]   ev_set;
  logic             unused_cfg;

  assign unused_cfg = ^{cfg_wdata[7], cfg_wdata[15]};
  assign depth_code = 4'(DEPTH_CODE);

  assign tx_flush = cfg_wr && cfg_wdata[CFG_TXFLUSH];
  assign rx_flush = cfg_wr && cfg_wdata[CFG_RXFLUSH];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr_m1 <= '0;
      rx_thr_m1 <= '0;
      rx_mode   <= 1'b0;
    end else begin
      if (cfg_wr) begin
        tx_thr_m1 <= cfg_wdata[CFG_TX_LSB +: THR_W];
        rx_thr_m1 <= cfg_wdata[CFG_RX_LSB +: THR_W];
      end
      if (xfer_start) rx_mode <= xfer_rx;
    end
  end

  assign tx_acc = host_wr && !tx_flush && (tx_level != LW'(DEPTH));
  assign rx_acc = eng_rx_push && !rx_flush && (rx_level != LW'(DEPTH));

  i2cf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(host_wr), .wdata(host_wdata),
    .pop(eng_tx_pop), .rdata(eng_tx_data), .level(tx_level));

  i2cf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(host_rd), .rdata(host_rdata), .level(rx_level));

  i2cf_left_ctr #(.CW(CW)) u_hleft (
    .clk(clk), .rst(rst), .load(xfer_start), .len(xfer_len),
    .dec(tx_acc), .left(host_left));

  i2cf_left_ctr #(.CW(CW)) u_eleft (
    .clk(clk), .rst(rst), .load(xfer_start), .len(xfer_len),
    .dec(rx_acc), .left(eng_left));

  assign tx_thr = CMPW'(tx_thr_m1) + CMPW'(1);
  assign rx_thr = CMPW'(rx_thr_m1) + CMPW'(1);
  assign tx_lv  = CMPW'(tx_level);
  assign rx_lv  = CMPW'(rx_level);
  assign h_left = CMPW'(host_left);
  assign e_left = CMPW'(eng_left);

  always_comb begin
    ev_set           = '0;
    ev_set[EV_TXREQ] = !rx_mode && (h_left != '0) && (tx_lv < tx_thr) && (h_left >= tx_thr);
    ev_set[EV_TXDRN] = !rx_mode && (h_left != '0) && (tx_lv < tx_thr) && (h_left < tx_thr);
    ev_set[EV_RXREQ] = rx_mode && (rx_lv >= rx_thr);
    ev_set[EV_RXDRN] = rx_mode && (e_left == '0) && (rx_lv != '0) && (rx_lv < rx_thr);
    ev_set[EV_DONE]  = eng_done;
    ev_set[EV_NACK]  = eng_nack;
    ev_set[EV_ARB]   = eng_arb_lost;
  end

  i2cf_status #(.N(NEV)) u_sts (
    .clk(clk), .rst(rst), .set(ev_set), .clr(sts_clr), .en(irq_en),
    .sts(status), .irq(irq));
endmodule

// File: rtl/i2cf_evt_chk.sv
module i2cf_evt_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_wr,
  input logic [15:0]   cfg_wdata,
  input logic          host_wr,
  input logic          host_rd,
  input logic [DW-1:0] host_rdata,
  input logic          eng_tx_pop,
  input logic          eng_rx_push,
  input logic          eng_done,
  input logic          eng_nack,
  input logic [6:0]    sts_clr,
  input logic [6:0]    irq_en,
  input logic [6:0]    status,
  input logic          irq,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level
);
  // R1: reset clears status and interrupt
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (status == '0 && irq == 1'b0 && tx_level == '0 && rx_level == '0));

  // R7: completion sets its status bit
  a_r7_done_sets: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> status[4]);

  // R8: a clear with no concurrent set removes the bit
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (sts_clr[5] && !eng_nack) |=> !status[5]);

  // R9: interrupt follows enabled status
  a_r9_irq_mask: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |(status & $past(irq_en))));

  // R11: full transmit FIFO holds its level against pushes
  a_r11_full_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_level == LW'(DEPTH) && host_wr && !eng_tx_pop && !(cfg_wr && cfg_wdata[6]))
      |=> tx_level == LW'(DEPTH));

  // R11: level never exceeds the depth
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    tx_level <= LW'(DEPTH) && rx_level <= LW'(DEPTH));

  // R12: empty read has no side effect
  a_r12_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0 && host_rd && !eng_rx_push) |=> ($stable(host_rdata) && rx_level == '0));
endmodule

bind i2c_fifo_evt i2cf_evt_chk #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
  .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
  .eng_done(eng_done), .eng_nack(eng_nack),
  .sts_clr(sts_clr), .irq_en(irq_en), .status(status), .irq(irq),
  .tx_level(tx_level), .rx_level(rx_level));

// File: tb/i2c_fifo_evt_test.sv
module i2c_fifo_evt_test;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int CW = 16;
  localparam int DEP = 8;
  localparam int LW = 4;

  logic clk = 0, rst = 1;
  logic xfer_start = 0, xfer_rx = 0, cfg_wr = 0;
  logic [CW-1:0] xfer_len = '0;
  logic [15:0] cfg_wdata = '0;
  logic host_wr = 0, host_rd = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [DW-1:0] host_wdata = '0, eng_rx_data = '0;
  logic eng_done = 0, eng_nack = 0, eng_arb_lost = 0;
  logic [6:0] sts_clr = '0, irq_en = '0;
  logic [DW-1:0] host_rdata, eng_tx_data;
  logic [6:0] status;
  logic irq;
  logic [LW-1:0] tx_level, rx_level;
  logic [3:0] depth_code;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_fifo_evt #(.DW(DW), .DEPTH_CODE(0), .CW(CW)) uut (.*);

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(int txt, int rxt, bit ftx, bit frx);
    cfg_wdata = 16'((txt - 1) | ((rxt - 1) << 8) | (int'(ftx) << 6) | (int'(frx) << 14));
    cfg_wr = 1; step(); cfg_wr = 0;
  endtask

  task automatic start(int len, bit rx);
    xfer_len = CW'(len); xfer_rx = rx; xfer_start = 1; step(); xfer_start = 0;
  endtask

  task automatic clr_all(logic [6:0] m);
    sts_clr = m; step(); sts_clr = '0;
  endtask

  task automatic hpush(int d);
    host_wdata = DW'(d); host_wr = 1; step(); host_wr = 0;
  endtask

  task automatic epush(int d);
    eng_rx_data = DW'(d); eng_rx_push = 1; step(); eng_rx_push = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 0;
    step();
    // R1 reset state
    chk(status == 0, "R1 status", status, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(tx_level == 0 && rx_level == 0, "R1 levels", {tx_level, rx_level}, 0);
    chk(depth_code == 0 && (8 << depth_code) == DEP, "R1 depth", depth_code, 0);

    // R2 R3 R4 R11: transmit sweep
    for (int thr = 1; thr <= 9; thr++) begin
      for (int len = 1; len <= 10; len++) begin
        int lvl, left, er, ed;
        cfg(thr, thr, 1, 1);
        start(len, 0);
        lvl = 0; left = len;
        for (int p = 0; p <= len; p++) begin
          if (p > 0) begin
            hpush(p);
            if (lvl < DEP) begin lvl++; left--; end
          end
          clr_all(7'h7f);
          er = (left != 0 && lvl < thr && left >= thr) ? 1 : 0;
          ed = (left != 0 && lvl < thr && left < thr) ? 1 : 0;
          chk(status[0] == er[0], "R3 tx request", status[0], er);
          chk(status[1] == ed[0], "R4 tx drain", status[1], ed);
          chk(status[3:2] == 0, "R2 rx idle in tx", status[3:2], 0);
          chk(tx_level == LW'(lvl), "R11 tx level", tx_level, lvl);
        end
      end
    end

    // R5 R6 R12 R13: receive sweep
    for (int thr = 1; thr <= 9; thr++) begin
      for (int len = 1; len <= 10; len++) begin
        int lvl, left, er, ed;
        int q [DEP];
        cfg(thr, thr, 1, 1);
        start(len, 1);
        lvl = 0; left = len;
        for (int p = 0; p <= len; p++) begin
          if (p > 0) begin
            epush((thr * 13 + p) & 8'hff);
            if (lvl < DEP) begin q[lvl] = (thr * 13 + p) & 8'hff; lvl++; left--; end
          end
          clr_all(7'h7f);
          er = (lvl >= thr) ? 1 : 0;
          ed = (left == 0 && lvl != 0 && lvl < thr) ? 1 : 0;
          chk(status[2] == er[0], "R5 rx request", status[2], er);
          chk(status[3] == ed[0], "R6 rx drain", status[3], ed);
          chk(status[1:0] == 0, "R2 tx idle in rx", status[1:0], 0);
        end
        for (int k = 0; k < lvl; k++) begin
          host_rd = 1; step(); host_rd = 0;
          chk(host_rdata == DW'(q[k]), "R13 rx order", host_rdata, q[k]);
        end
        host_rd = 1; step(); host_rd = 0; step();
        chk(host_rdata == DW'(q[lvl-1]), "R12 empty read data", host_rdata, q[lvl-1]);
        chk(rx_level == 0, "R12 empty read level", rx_level, 0);
      end
    end

    // R11 R13: transmit order, full push dropped
    cfg(1, 1, 1, 1);
    start(20, 0);
    for (int i = 0; i < 9; i++) hpush(8'ha0 + i);
    chk(tx_level == LW'(DEP), "R11 full level", tx_level, DEP);
    for (int i = 0; i < 8; i++) begin
      eng_tx_pop = 1; step(); eng_tx_pop = 0;
      chk(eng_tx_data == DW'(8'ha0 + i), "R13 tx order", eng_tx_data, 8'ha0 + i);
    end
    chk(tx_level == 0, "R11 dropped byte absent", tx_level, 0);

    // R10 independent flushes
    for (int i = 0; i < 3; i++) begin hpush(i); epush(i); end
    chk(tx_level == 3 && rx_level == 3, "R10 prefill", {tx_level, rx_level}, 8'h33);
    cfg(1, 1, 1, 0);
    chk(tx_level == 0 && rx_level == 3, "R10 tx flush", {tx_level, rx_level}, 8'h03);
    cfg(1, 1, 0, 1);
    chk(rx_level == 0, "R10 rx flush", rx_level, 0);

    // R7 R8 R9: engine events, masking, clearing
    start(0, 0);
    step();
    clr_all(7'h7f);
    chk(status == 0, "R8 idle clear", status, 0);
    for (int b = 4; b <= 6; b++) begin
      irq_en = '0;
      eng_done = (b == 4); eng_nack = (b == 5); eng_arb_lost = (b == 6);
      step();
      eng_done = 0; eng_nack = 0; eng_arb_lost = 0;
      step();
      chk(status == 7'(1 << b), "R7 event bit", status, 1 << b);
      chk(irq == 0, "R9 masked", irq, 0);
      for (int k = 0; k < 7; k++) begin
        irq_en = 7'(1 << k); step();
        chk(irq == (k == b), "R9 enable", irq, (k == b));
      end
      irq_en = '0;
      clr_all(7'h7f & ~7'(1 << b));
      chk(status == 7'(1 << b), "R8 zero no effect", status, 1 << b);
      clr_all(7'(1 << b));
      chk(status == 0, "R8 one clears", status, 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule